// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block runs after a translation miss. It takes a virtual address, the kind of access (instruction fetch or data), and the translation table base register. It reads descriptors from memory until it has a page frame base, or until it finds a fault. The result goes back to the lookaside buffer that started the walk.

**Walk sequence**
- The first read fetches a level-1 descriptor. Its type field picks one of three paths:
  - a section of 1 MB, which completes in one read;
  - a coarse second-level table of 256 entries;
  - a fine second-level table of 1024 entries.
- For a coarse or fine table, the walker makes a second read to fetch the level-2 descriptor.
- The level-2 descriptor type then selects a large page (64 KB), a small page (4 KB), a tiny page (1 KB) or a fault.

**Result and fault reporting**
- The result gives the frame base, a size code, the domain, the access permission bits selected for the touched sub-page, and the cacheable and bufferable bits.
- A fault is flagged as either an instruction fault or a data fault. The result also shows whether the faulting descriptor was at level 1 or level 2.

**Memory port and handshake**
- Memory is reached through a plain port. The request is a one-cycle pulse with a word address. The response is a one-cycle pulse with the data, returned after any latency.
- Only one read is ever in flight.
- Requests from the lookaside buffer are taken only while the walker is not busy.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `busy`, `mem_req_valid` and `done_valid` are low. A walk is accepted on a clock edge where `req_valid` is high and `busy` is low. `req_valid` is ignored while `busy` is high.
- R2: The first read address is `{ttb[31:14], va[31:20], 2'b00}`. Bits [13:0] of the base register have no effect on any read address.
- R3: Level-1 type bits [1:0] are decoded as follows:
  - 2'b00: fault.
  - 2'b01: coarse table.
  - 2'b10: section.
  - 2'b11: fine table.
- R4: A section descriptor ends the walk after exactly one read, with these result fields:
  - frame = `{desc[31:20], 20'h0}`, size code 0 (1 MB);
  - permission = desc[11:10], domain = desc[8:5];
  - cacheable = desc[3], bufferable = desc[2].
- R5: The second read address depends on the table type:
  - coarse: `{l1[31:10], va[19:12], 2'b00}`;
  - fine: `{l1[31:12], va[19:10], 2'b00}`.
- R6: Level-2 type bits [1:0] are decoded as follows:
  - 2'b00: fault.
  - 2'b01: large page. Frame = `{d[31:16],16'h0}`, size code 1.
  - 2'b10: small page. Frame = `{d[31:12],12'h0}`, size code 2.
  - 2'b11: tiny page. Frame = `{d[31:10],10'h0}`, size code 3.
  - In every page case, cacheable = d[3], bufferable = d[2], and the domain is taken from the level-1 descriptor bits [8:5].
- R7: Large and small pages carry four permission fields; field n sits at d[2n+5:2n+4]. The index n is va[15:14] for a large page and va[11:10] for a small page. A tiny page always uses d[5:4].
- R8: A fault at either level raises `done_ifault` for an instruction access or `done_dfault` for a data access, never both. `done_fault_l2` is 1 only for a level-2 fault. All other result fields are zero on a fault.
- R9: At most two reads are made per walk. `mem_req_valid` is never high while a read is outstanding. `busy` is high from acceptance until `done_valid`.
- R10: `done_valid` is a one-cycle pulse, and `busy` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a walk |
| req_va | input | 32 | Virtual address to translate |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| ttb | input | 32 | Translation table base register |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | 32 | Word address of the descriptor |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor read from memory |
| done_valid | output | 1 | Result valid, one cycle |
| done_frame | output | 32 | Page frame base address |
| done_size | output | 2 | 0 = 1 MB, 1 = 64 KB, 2 = 4 KB, 3 = 1 KB |
| done_domain | output | 4 | Domain number |
| done_ap | output | 2 | Selected access permission field |
| done_c | output | 1 | Cacheable |
| done_b | output | 1 | Bufferable |
| done_ifault | output | 1 | Instruction-side translation fault |
| done_dfault | output | 1 | Data-side translation fault |
| done_fault_l2 | output | 1 | Fault came from the level-2 descriptor |

## Verification
The assertions take for granted that memory returns exactly one response for each request, and never a response the walker has not asked for. The read counter in the checker depends on that pairing. The bench meets this by acting as the memory itself: it answers only after it has seen a request pulse, waits one to four cycles, and sends one response. While a walk is running, the bench keeps driving `req_valid` with unrelated addresses. This shows that those requests are dropped and do not break the one-read-at-a-time rule the assertions check.

// File: rtl/xw_pkg.sv
// Shared definitions for the translation table walker.
// Assumes 32-bit virtual and physical addresses and 32-bit descriptors.
package xw_pkg;
    localparam int DESC_W    = 32;
    localparam int DOM_W     = 4;
    localparam int AP_W      = 2;
    localparam int N_SUBPG   = 4;
    localparam int L1_SHIFT  = 20;            // 1 MB per level-1 entry
    localparam int TTB_ALIGN = 14;            // 16 KB aligned level-1 table
    localparam int L1_IDX_W  = DESC_W - L1_SHIFT;
    localparam int AP_LSB    = 4;

    typedef enum logic [1:0] {
        PG_1M  = 2'd0,
        PG_64K = 2'd1,
        PG_4K  = 2'd2,
        PG_1K  = 2'd3
    } xw_size_e;

    typedef enum logic [1:0] {
        L1_FAULT   = 2'd0,
        L1_COARSE  = 2'd1,
        L1_SECTION = 2'd2,
        L1_FINE    = 2'd3
    } xw_l1_kind_e;

    typedef struct packed {
        logic [DESC_W-1:0] frame;
        xw_size_e          size;
        logic [DOM_W-1:0]  domain;
        logic [AP_W-1:0]   ap;
        logic              c;
        logic              b;
        logic              fault;
        logic              fault_l2;
    } xw_result_t;
endpackage

// File: rtl/xw_l1_decode.sv
// Level-1 descriptor decoder.
// Classifies the descriptor, builds the section result and forms the
// second-level read address. Purely combinational.
module xw_l1_decode
    import xw_pkg::*;
(
    input  logic [DESC_W-1:0] l1_desc,
    input  logic [DESC_W-1:0] va,
    output xw_l1_kind_e       kind,
    output xw_result_t        sec_res,
    output logic [DESC_W-1:0] l2_addr
);
    // type field to kind
    always_comb kind = xw_l1_kind_e'(l1_desc[1:0]);

    // result fields of a section mapping
    always_comb begin
        sec_res        = '0;
        sec_res.frame  = {l1_desc[DESC_W-1:L1_SHIFT], {L1_SHIFT{1'b0}}};
        sec_res.size   = PG_1M;
        sec_res.ap     = l1_desc[11:10];
        sec_res.domain = l1_desc[8:5];
        sec_res.c      = l1_desc[3];
        sec_res.b      = l1_desc[2];
    end

    // second-level table entry address for coarse or fine tables
    always_comb begin
        unique case (kind)
            L1_COARSE: l2_addr = {l1_desc[31:10], va[19:12], 2'b00};
            L1_FINE:   l2_addr = {l1_desc[31:12], va[19:10], 2'b00};
            default:   l2_addr = '0;
        endcase
    end
endmodule

// File: rtl/xw_l2_decode.sv
// Level-2 descriptor decoder.
// Produces the page result, or a level-2 fault. Picks the permission
// field of the touched sub-page for large and small pages. The domain
// comes from the level-1 descriptor. Purely combinational.
module xw_l2_decode
    import xw_pkg::*;
(
    input  logic [DESC_W-1:0] l2_desc,
    input  logic [DESC_W-1:0] l1_desc,
    input  logic [DESC_W-1:0] va,
    output xw_result_t        res
);
    logic [AP_W-1:0] ap_field [N_SUBPG];
    logic [1:0]      sel;

    // split out the four permission fields
    for (genvar g = 0; g < N_SUBPG; g++) begin : g_apf
        assign ap_field[g] = l2_desc[AP_LSB + AP_W*g +: AP_W];
    end

    // sub-page index from the address bits just below the page size
    always_comb begin
        unique case (l2_desc[1:0])
            2'b01:   sel = va[15:14];
            2'b10:   sel = va[11:10];
            default: sel = 2'b00;
        endcase
    end

    // assemble the result
    always_comb begin
        res = '0;
        if (l2_desc[1:0] == 2'b00) begin
            res.fault    = 1'b1;
            res.fault_l2 = 1'b1;
        end else begin
            res.domain = l1_desc[8:5];
            res.ap     = ap_field[sel];
            res.c      = l2_desc[3];
            res.b      = l2_desc[2];
            unique case (l2_desc[1:0])
                2'b01:   begin res.frame = {l2_desc[31:16], 16'h0}; res.size = PG_64K; end
                2'b10:   begin res.frame = {l2_desc[31:12], 12'h0}; res.size = PG_4K;  end
                default: begin res.frame = {l2_desc[31:10], 10'h0}; res.size = PG_1K;  end
            endcase
        end
    end
endmodule

// File: rtl/xlat_walker.sv
// Two-level translation table walker.
// Accepts one walk at a time and keeps a single memory read in flight.
// Returns a one-cycle result pulse. Assumes memory answers each request
// with exactly one response pulse, no earlier than the cycle after the
// request.
module xlat_walker
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_va,
    input  logic              req_instr,
    input  logic [31:0]       ttb,
    output logic              busy,
    output logic              mem_req_valid,
    output logic [31:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              done_valid,
    output logic [31:0]       done_frame,
    output logic [1:0]        done_size,
    output logic [3:0]        done_domain,
    output logic [1:0]        done_ap,
    output logic              done_c,
    output logic              done_b,
    output logic              done_ifault,
    output logic              done_dfault,
    output logic              done_fault_l2
);
    typedef enum logic [2:0] {
        S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE
    } state_e;

    state_e                    state_q;
    logic [DESC_W-1:0]         va_q;
    logic [DESC_W-1:TTB_ALIGN] ttb_q;
    logic                      instr_q;
    logic [DESC_W-1:0]         l1_q;
    xw_result_t                res_q;

    logic [DESC_W-1:0] l1_in;
    xw_l1_kind_e       l1_kind;
    xw_result_t        sec_res;
    xw_result_t        pg_res;
    logic [DESC_W-1:0] l2_addr;
    logic [DESC_W-1:0] l1_addr;

    // level-1 decode: live response while waiting, held copy afterwards
    always_comb l1_in = (state_q == S_L1_WAIT) ? mem_rsp_data : l1_q;

    xw_l1_decode u_l1 (
        .l1_desc (l1_in),
        .va      (va_q),
        .kind    (l1_kind),
        .sec_res (sec_res),
        .l2_addr (l2_addr)
    );

    xw_l2_decode u_l2 (
        .l2_desc (mem_rsp_data),
        .l1_desc (l1_q),
        .va      (va_q),
        .res     (pg_res)
    );

    // level-1 entry address from the aligned base and the top address bits
    always_comb l1_addr = {ttb_q, va_q[DESC_W-1:L1_SHIFT], 2'b00};

    // walk sequencer and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            va_q    <= '0;
            ttb_q   <= '0;
            instr_q <= 1'b0;
            l1_q    <= '0;
            res_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    va_q    <= req_va;
                    ttb_q   <= ttb[DESC_W-1:TTB_ALIGN];
                    instr_q <= req_instr;
                    state_q <= S_L1_REQ;
                end
                S_L1_REQ: state_q <= S_L1_WAIT;
                S_L1_WAIT: if (mem_rsp_valid) begin
                    l1_q <= mem_rsp_data;
                    unique case (l1_kind)
                        L1_FAULT: begin
                            res_q       <= '0;
                            res_q.fault <= 1'b1;
                            state_q     <= S_DONE;
                        end
                        L1_SECTION: begin
                            res_q   <= sec_res;
                            state_q <= S_DONE;
                        end
                        default: state_q <= S_L2_REQ;
                    endcase
                end
                S_L2_REQ: state_q <= S_L2_WAIT;
                S_L2_WAIT: if (mem_rsp_valid) begin
                    res_q   <= pg_res;
                    state_q <= S_DONE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // memory request and status outputs
    always_comb begin
        busy          = (state_q != S_IDLE);
        mem_req_valid = (state_q == S_L1_REQ) || (state_q == S_L2_REQ);
        mem_req_addr  = (state_q == S_L2_REQ) ? l2_addr : l1_addr;
    end

    // result outputs
    always_comb begin
        done_valid    = (state_q == S_DONE);
        done_frame    = res_q.frame;
        done_size     = res_q.size;
        done_domain   = res_q.domain;
        done_ap       = res_q.ap;
        done_c        = res_q.c;
        done_b        = res_q.b;
        done_ifault   = res_q.fault & instr_q;
        done_dfault   = res_q.fault & ~instr_q;
        done_fault_l2 = res_q.fault_l2;
    end
endmodule

// File: rtl/xw_checker.sv
// Protocol and result checks for xlat_walker, bound to every instance.
// Assumes exactly one memory response for each request.
module xw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mem_req_valid,
    input logic [31:0] mem_req_addr,
    input logic        done_valid,
    input logic [31:0] done_frame,
    input logic [1:0]  done_size,
    input logic [1:0]  done_ap,
    input logic        done_ifault,
    input logic        done_dfault,
    input logic        done_fault_l2
);
    logic [1:0] rd_cnt;

    // count reads issued in the current walk
    always_ff @(posedge clk) begin
        if (!rst_n)             rd_cnt <= '0;
        else if (done_valid)    rd_cnt <= '0;
        else if (mem_req_valid) rd_cnt <= rd_cnt + 2'd1;
    end

    logic any_fault;
    always_comb any_fault = done_ifault | done_dfault;

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);                                               // R9
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);                                     // R9
    AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> rd_cnt < 2'd2);                                      // R9
    AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);                         // R2
    AST_SECTION_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !any_fault && done_size == 2'd0) |-> rd_cnt == 2'd1);   // R4
    AST_L1_FAULT_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && any_fault && !done_fault_l2) |-> rd_cnt == 2'd1);       // R8
    AST_L2_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && (done_fault_l2 || (!any_fault && done_size != 2'd0)))
            |-> rd_cnt == 2'd2);                                               // R6
    AST_FAULT_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $countones({done_ifault, done_dfault}) <= 1);           // R8
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && any_fault) |-> (done_frame == 32'h0 && done_ap == 2'b00)); // R8
    AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_size == 2'd2) |-> done_frame[11:0] == 12'h0);      // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);                                           // R10
    AST_FREE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !busy);                                                 // R10
endmodule

bind xlat_walker xw_checker u_xw_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .done_valid    (done_valid),
    .done_frame    (done_frame),
    .done_size     (done_size),
    .done_ap       (done_ap),
    .done_ifault   (done_ifault),
    .done_dfault   (done_dfault),
    .done_fault_l2 (done_fault_l2)
);

// File: tb/sim_xlat_walker.sv
// Bench for xlat_walker. The bench plays the memory, predicts every walk
// from the requirement text, and mixes random walks with directed cases.
module sim_xlat_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_instr = 1'b0;
    logic [31:0] ttb = '0;
    logic        busy, mem_req_valid, done_valid;
    logic [31:0] mem_req_addr, done_frame;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic [1:0]  done_size, done_ap;
    logic [3:0]  done_domain;
    logic        done_c, done_b, done_ifault, done_dfault, done_fault_l2;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    xlat_walker u0 (.*);

    // expected values
    logic [31:0] e_a1, e_a2, e_frame;
    logic [1:0]  e_size, e_ap;
    logic [3:0]  e_dom;
    logic        e_c, e_b, e_if, e_df, e_l2;
    int          e_reads;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model written from the requirements
    task automatic predict(input logic [31:0] va, input logic [31:0] tb,
                           input logic instr, input logic [31:0] l1, input logic [31:0] l2);
        logic [1:0] sel;
        e_a1 = {tb[31:14], va[31:20], 2'b00};   // R2
        e_a2 = '0; e_frame = '0; e_size = '0; e_ap = '0; e_dom = '0;
        e_c = 0; e_b = 0; e_if = 0; e_df = 0; e_l2 = 0; e_reads = 1;
        case (l1[1:0])                           // R3
            2'b00: begin e_if = instr; e_df = !instr; end
            2'b10: begin                         // R4
                e_frame = {l1[31:20], 20'h0}; e_ap = l1[11:10];
                e_dom = l1[8:5]; e_c = l1[3]; e_b = l1[2];
            end
            default: begin
                e_reads = 2;
                e_a2 = (l1[1:0] == 2'b01) ? {l1[31:10], va[19:12], 2'b00}
                                          : {l1[31:12], va[19:10], 2'b00};  // R5
                if (l2[1:0] == 2'b00) begin
                    e_if = instr; e_df = !instr; e_l2 = 1;                 // R8
                end else begin                                             // R6
                    e_dom = l1[8:5]; e_c = l2[3]; e_b = l2[2];
                    case (l2[1:0])
                        2'b01:   begin e_frame = {l2[31:16],16'h0}; e_size = 1; sel = va[15:14]; end
                        2'b10:   begin e_frame = {l2[31:12],12'h0}; e_size = 2; sel = va[11:10]; end
                        default: begin e_frame = {l2[31:10],10'h0}; e_size = 3; sel = 0; end
                    endcase
                    e_ap = l2[4 + 2*sel +: 2];                             // R7
                end
            end
        endcase
    endtask

    // run one walk; noise keeps req_valid high with junk while busy
    task automatic walk(input logic [31:0] va, input logic [31:0] tb, input logic instr,
                        input logic [31:0] l1, input logic [31:0] l2, input bit noise);
        int reads = 0;
        int cyc = 0;
        bit fin = 0;
        predict(va, tb, instr, l1, l2);
        @(negedge clk);
        req_valid = 1; req_va = va; ttb = tb; req_instr = instr;
        @(negedge clk);
        chk("R1 busy after accept", busy, 1);
        req_valid = noise; req_va = $urandom; ttb = $urandom; req_instr = $urandom;
        while (!fin && cyc < 200) begin
            if (mem_req_valid) begin
                reads++;
                if (reads == 1) chk("R2 level-1 address", mem_req_addr, e_a1);
                else            chk("R5 level-2 address", mem_req_addr, e_a2);
                repeat (1 + ($urandom % 4)) @(negedge clk);
                mem_rsp_valid = 1; mem_rsp_data = (reads == 1) ? l1 : l2;
                @(negedge clk);
                mem_rsp_valid = 0; mem_rsp_data = $urandom;
                cyc += 5;
            end else if (done_valid) begin
                fin = 1;
                req_valid = 0;
                chk("R9 read count", reads, e_reads);
                chk("R4 R6 frame", done_frame, e_frame);
                chk("R6 size", done_size, e_size);
                chk("R7 permission", done_ap, e_ap);
                chk("R6 domain", done_domain, e_dom);
                chk("R6 cache bits", {done_c, done_b}, {e_c, e_b});
                chk("R8 fault flags", {done_ifault, done_dfault, done_fault_l2}, {e_if, e_df, e_l2});
                @(negedge clk);
                chk("R10 done pulse", done_valid, 0);
                chk("R10 idle after done", busy, 0);
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL R9 walk hung actual=no result expected=result");
            req_valid = 0;
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset mem_req_valid", mem_req_valid, 0);
        chk("R1 reset done_valid", done_valid, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle no request", mem_req_valid, 0);
        // directed: section with junk base low bits
        walk(32'hABC1_2345, 32'h1234_7FFF, 0, 32'hFED0_0DEE, 0, 0);
        // level-1 fault, instruction and data side
        walk(32'h0010_0000, 32'h0000_4000, 1, 32'h1234_5670, 0, 0);
        walk(32'h0010_0000, 32'h0000_4000, 0, 32'h1234_567C, 0, 0);
        // coarse to large page, each quarter
        for (int q = 0; q < 4; q++)
            walk({16'h0040, q[1:0], 14'h0ABC}, 32'h8000_0000, 0, 32'h0001_0C01, 32'hCAFE_E4DD, 1);
        // fine to small page, each quarter
        for (int q = 0; q < 4; q++)
            walk({20'h00503, q[1:0], 10'h155}, 32'h8000_0000, 1, 32'h0002_3003, 32'h7654_3E4E, 1);
        // fine to tiny page, coarse to level-2 fault
        walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 32'h1234_56FF, 0);
        walk(32'h0000_0000, 32'h0000_0000, 1, 32'h0000_0001, 32'hFFFF_FFFC, 1);
        // random mix
        for (int i = 0; i < 300; i++)
            walk($urandom, $urandom, $urandom, $urandom, $urandom, $urandom % 2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule